// File: doc/BRIEF.md
# Dual-Side Integrator Conversion Sequencer

This block sequences a converter front end built around two integrators, called side A and side B. A host supplies a conversion control level (CONV) and a clock. Each CONV edge ends the integration in progress and, depending on how busy the measurement path is, either starts the other side integrating at once or falls back to a mode in which both integrators are idle while the measurement path catches up. The block drives an integrate enable and a measure/reset/auto-zero (m/r/az) enable for each side, a measurement-busy flag, a state index, an active-low data-ready flag and a tag naming the side whose result is waiting.

The eight states come in mirrored pairs (1/8, 2/7, 3/6, 4/5). States 3 to 6 are continuous operation: one side always integrates. States 1, 2, 7 and 8 are non-continuous: the inputs are treated as grounded. The m/r/az and data-ready delays are counted in clock cycles with parameters. The host acknowledges data by pulling the transfer strobe low, which releases the ready flag.

Top module: `dual_int_sequencer`

## Requirements
- R1: While reset is high the state index is 1 when CONV is high and 8 when CONV is low; the ready flag is high (idle), busy is low and both integrate enables are low.
- R2: The state index `state_o` is the state number 1..8. Integrate enable A is high exactly in states 3 and 5, enable B exactly in states 4 and 6, and both are low in states 1, 2, 7 and 8.
- R3: In state 1 (or 8) with busy low the block moves to state 2 (or 7) on the next cycle; a CONV edge in state 2 leads to state 3, in state 7 to state 6.
- R4: A CONV edge in state 3 leads to 4, in state 6 to 5; in state 4 or 5 an edge with busy low swaps between 4 and 5. For any CONV pattern, consecutive integrations alternate between A and B.
- R5: A CONV edge with busy high in state 4 leads to state 1, in state 5 to state 8; further edges while busy stay in state 1 (or 8).
- R6: Applying the inverted CONV pattern from reset yields, at every step, the state 9 minus the state of the non-inverted run.
- R7: Entering state 4 from 3 or 5 starts an m/r/az of side A, entering 5 from 4 or 6 one of side B; busy is then high for exactly MRAZ_CONT_CYC cycles and the m/r/az enable of that side is high only while busy.
- R8: Entering state 1 or 8 from 4 or 5 restarts busy for exactly MRAZ_NCONT_CYC cycles, with both m/r/az enables high and both integrate enables low.
- R9: After a continuous m/r/az start, the ready flag goes low RDY_CONT_CYC cycles after busy rises, with `data_side_o` naming the side under m/r/az (0 = A, 1 = B).
- R10: After a non-continuous start, the ready flag goes low RDY_NCONT1_CYC cycles after the start tagged with the side that was under m/r/az, and again RDY_NCONT2_CYC cycles after the start tagged with the other side.
- R11: Once low, the ready flag stays low until the transfer strobe is sampled low; it is high on the cycle after that.
- R12: CONV passes a two-flop synchroniser; a CONV change made before a clock edge moves the state on the third rising edge, and a steady CONV level causes no transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_i | input | 1 | Conversion control level from the host |
| dxmit_n_i | input | 1 | Data transfer strobe, active low, clears the ready flag |
| int_en_a_o | output | 1 | Integrate enable, side A |
| int_en_b_o | output | 1 | Integrate enable, side B |
| mraz_a_o | output | 1 | Measure/reset/auto-zero enable, side A |
| mraz_b_o | output | 1 | Measure/reset/auto-zero enable, side B |
| busy_o | output | 1 | Measurement-busy flag |
| state_o | output | 4 | Current state number 1..8 |
| dvalid_n_o | output | 1 | Data ready, active low |
| data_side_o | output | 1 | Side of the flagged data, 0 = A, 1 = B |

## Verification
The bench walks one CONV pattern and then its inverse, so a design with a broken mirror pair or a lost busy test lands in the wrong state, and it toggles CONV inside and outside the busy window so that a block ignoring busy would stay continuous where it must drop to state 1 or 8. Ready latencies and busy length are counted edge by edge from the CONV change, so an extra or missing register or an off-by-one timer shows as a shifted count, and the two non-continuous ready events must carry opposite side tags. A long random CONV sequence checks that no side ever integrates twice in a row, and holding the transfer strobe high catches a ready flag that clears by itself.

// File: rtl/dis_pkg.sv
package dis_pkg;

    typedef enum logic [3:0] {
        ST1 = 4'd1,
        ST2 = 4'd2,
        ST3 = 4'd3,
        ST4 = 4'd4,
        ST5 = 4'd5,
        ST6 = 4'd6,
        ST7 = 4'd7,
        ST8 = 4'd8
    } seq_state_e;

    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    typedef struct packed {
        logic a;
        logic b;
    } pair_en_t;

    // Integrate enables implied by a state.
    function automatic pair_en_t integ_of(seq_state_e s);
        pair_en_t r;
        r.a = (s == ST3) || (s == ST5);
        r.b = (s == ST4) || (s == ST6);
        return r;
    endfunction

    function automatic logic is_grounded(seq_state_e s);
        return (s == ST1) || (s == ST2) || (s == ST7) || (s == ST8);
    endfunction

endpackage

// File: rtl/conv_edge_sync.sv
module conv_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic conv_i,
    output logic conv_tgl_o
);
    localparam int W = SYNC_STAGES + 1;

    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= {W{conv_i}};
        end else begin
            sh_q <= {sh_q[W-2:0], conv_i};
        end
    end

    // Compare last synchronised sample with the one before it.
    assign conv_tgl_o = sh_q[W-2] ^ sh_q[W-1];
endmodule

// File: rtl/mraz_timer.sv
module mraz_timer #(
    parameter int LEN_CONT  = 4794,
    parameter int LEN_NCONT = 9108,
    parameter int RDY_CONT  = 4212,
    parameter int RDY_NC1   = 4212,
    parameter int RDY_NC2   = 4548
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic ncont_i,
    output logic busy_o,
    output logic rdy1_o,
    output logic rdy2_o
);
    localparam int MAXLEN = (LEN_NCONT > LEN_CONT) ? LEN_NCONT : LEN_CONT;
    localparam int CW     = $clog2(MAXLEN + 1);
    localparam logic [CW-1:0] END_C  = CW'(LEN_CONT - 1);
    localparam logic [CW-1:0] END_N  = CW'(LEN_NCONT - 1);
    localparam logic [CW-1:0] HIT_C  = CW'(RDY_CONT - 1);
    localparam logic [CW-1:0] HIT_N1 = CW'(RDY_NC1 - 1);
    localparam logic [CW-1:0] HIT_N2 = CW'(RDY_NC2 - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          nc_q;
    logic [CW-1:0] end_cnt;

    assign end_cnt = nc_q ? END_N : END_C;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            nc_q   <= 1'b0;
        end else if (start_i) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
            nc_q   <= ncont_i;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == end_cnt) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy_o = busy_q;
    assign rdy1_o = busy_q && !start_i && (nc_q ? (cnt_q == HIT_N1) : (cnt_q == HIT_C));
    assign rdy2_o = busy_q && !start_i && nc_q && (cnt_q == HIT_N2);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import dis_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       conv_lvl_i,
    input  logic       conv_tgl_i,
    input  logic       busy_i,
    output seq_state_e state_o,
    output logic       start_o,
    output logic       ncont_o,
    output side_e      mraz_side_o
);
    seq_state_e st_q, st_d;
    side_e      side_q, side_d;

    always_comb begin
        st_d    = st_q;
        side_d  = side_q;
        start_o = 1'b0;
        ncont_o = 1'b0;
        case (st_q)
            ST1: if (!busy_i) st_d = ST2;
            ST8: if (!busy_i) st_d = ST7;
            ST2: if (conv_tgl_i) st_d = ST3;
            ST7: if (conv_tgl_i) st_d = ST6;
            ST3: if (conv_tgl_i) begin
                st_d = ST4; start_o = 1'b1; side_d = SIDE_A;
            end
            ST6: if (conv_tgl_i) begin
                st_d = ST5; start_o = 1'b1; side_d = SIDE_B;
            end
            ST4: if (conv_tgl_i) begin
                start_o = 1'b1;
                if (busy_i) begin
                    st_d = ST1; ncont_o = 1'b1; side_d = SIDE_A;
                end else begin
                    st_d = ST5; side_d = SIDE_B;
                end
            end
            ST5: if (conv_tgl_i) begin
                start_o = 1'b1;
                if (busy_i) begin
                    st_d = ST8; ncont_o = 1'b1; side_d = SIDE_B;
                end else begin
                    st_d = ST4; side_d = SIDE_A;
                end
            end
            default: st_d = ST1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= conv_lvl_i ? ST1 : ST8;
            side_q <= SIDE_A;
        end else begin
            st_q   <= st_d;
            side_q <= side_d;
        end
    end

    assign state_o     = st_q;
    assign mraz_side_o = side_q;
endmodule

// File: rtl/ready_flag.sv
module ready_flag
    import dis_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rdy1_i,
    input  logic  rdy2_i,
    input  side_e first_side_i,
    input  logic  dxmit_n_i,
    output logic  dvalid_n_o,
    output side_e side_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dvalid_n_o <= 1'b1;
            side_o     <= SIDE_A;
        end else if (rdy1_i) begin
            dvalid_n_o <= 1'b0;
            side_o     <= first_side_i;
        end else if (rdy2_i) begin
            dvalid_n_o <= 1'b0;
            side_o     <= (first_side_i == SIDE_A) ? SIDE_B : SIDE_A;
        end else if (!dxmit_n_i) begin
            dvalid_n_o <= 1'b1;
        end
    end
endmodule

// File: rtl/dual_int_sequencer.sv
module dual_int_sequencer
    import dis_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int MRAZ_CONT_CYC  = 4794,
    parameter int MRAZ_NCONT_CYC = 9108,
    parameter int RDY_CONT_CYC   = 4212,
    parameter int RDY_NCONT1_CYC = 4212,
    parameter int RDY_NCONT2_CYC = 4548
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       conv_i,
    input  logic       dxmit_n_i,
    output logic       int_en_a_o,
    output logic       int_en_b_o,
    output logic       mraz_a_o,
    output logic       mraz_b_o,
    output logic       busy_o,
    output logic [3:0] state_o,
    output logic       dvalid_n_o,
    output logic       data_side_o
);
    logic       conv_tgl;
    logic       busy;
    logic       start;
    logic       ncont;
    logic       rdy1;
    logic       rdy2;
    seq_state_e state;
    side_e      mraz_side;
    side_e      data_side;
    pair_en_t   integ;
    logic       gnd;

    conv_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst        (rst),
        .conv_i     (conv_i),
        .conv_tgl_o (conv_tgl)
    );

    seq_fsm i_fsm (
        .clk         (clk),
        .rst         (rst),
        .conv_lvl_i  (conv_i),
        .conv_tgl_i  (conv_tgl),
        .busy_i      (busy),
        .state_o     (state),
        .start_o     (start),
        .ncont_o     (ncont),
        .mraz_side_o (mraz_side)
    );

    mraz_timer #(
        .LEN_CONT  (MRAZ_CONT_CYC),
        .LEN_NCONT (MRAZ_NCONT_CYC),
        .RDY_CONT  (RDY_CONT_CYC),
        .RDY_NC1   (RDY_NCONT1_CYC),
        .RDY_NC2   (RDY_NCONT2_CYC)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .ncont_i (ncont),
        .busy_o  (busy),
        .rdy1_o  (rdy1),
        .rdy2_o  (rdy2)
    );

    ready_flag i_ready (
        .clk          (clk),
        .rst          (rst),
        .rdy1_i       (rdy1),
        .rdy2_i       (rdy2),
        .first_side_i (mraz_side),
        .dxmit_n_i    (dxmit_n_i),
        .dvalid_n_o   (dvalid_n_o),
        .side_o       (data_side)
    );

    assign integ       = integ_of(state);
    assign gnd         = is_grounded(state);
    assign int_en_a_o  = integ.a;
    assign int_en_b_o  = integ.b;
    assign mraz_a_o    = busy && (gnd || (state == ST4));
    assign mraz_b_o    = busy && (gnd || (state == ST5));
    assign busy_o      = busy;
    assign state_o     = state;
    assign data_side_o = data_side;
endmodule

// File: rtl/dis_checker.sv
module dis_checker (
    input logic       clk,
    input logic       rst,
    input logic       dxmit_n_i,
    input logic       int_en_a_o,
    input logic       int_en_b_o,
    input logic       mraz_a_o,
    input logic       mraz_b_o,
    input logic       busy_o,
    input logic [3:0] state_o,
    input logic       dvalid_n_o
);
    AST_STATE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state_o >= 4'd1) && (state_o <= 4'd8)); // R2

    AST_ONE_SIDE_INTEGRATES: assert property (@(posedge clk) disable iff (rst)
        !(int_en_a_o && int_en_b_o)); // R2

    AST_GROUNDED_NO_INTEGRATE: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd1 || state_o == 4'd2 || state_o == 4'd7 || state_o == 4'd8)
        |-> (!int_en_a_o && !int_en_b_o)); // R2

    AST_PREP_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd2 || state_o == 4'd7) |-> !busy_o); // R3

    AST_SIDES_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        ((int_en_a_o || int_en_b_o) && ($past(int_en_a_o) || $past(int_en_b_o))
         && !$stable(state_o)) |-> (int_en_a_o != $past(int_en_a_o))); // R4

    AST_MRAZ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        (mraz_a_o || mraz_b_o) |-> busy_o); // R7

    AST_INTEGRATE_ONLY_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd3 || state_o == 4'd6) |-> !busy_o); // R7

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!dvalid_n_o && dxmit_n_i) |=> !dvalid_n_o); // R11
endmodule

bind dual_int_sequencer dis_checker i_dis_checker (
    .clk        (clk),
    .rst        (rst),
    .dxmit_n_i  (dxmit_n_i),
    .int_en_a_o (int_en_a_o),
    .int_en_b_o (int_en_b_o),
    .mraz_a_o   (mraz_a_o),
    .mraz_b_o   (mraz_b_o),
    .busy_o     (busy_o),
    .state_o    (state_o),
    .dvalid_n_o (dvalid_n_o)
);

// File: tb/test_dual_int_sequencer.sv
module test_dual_int_sequencer;
    localparam int LC  = 20;
    localparam int LN  = 40;
    localparam int DC  = 12;
    localparam int DN1 = 12;
    localparam int DN2 = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic conv = 1'b1;
    logic dxmit_n = 1'b1;
    logic int_a, int_b, mraz_a, mraz_b, busy, dvalid_n, side;
    logic [3:0] state;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    dual_int_sequencer #(
        .SYNC_STAGES(2), .MRAZ_CONT_CYC(LC), .MRAZ_NCONT_CYC(LN),
        .RDY_CONT_CYC(DC), .RDY_NCONT1_CYC(DN1), .RDY_NCONT2_CYC(DN2)
    ) i_dual_int_sequencer (
        .clk(clk), .rst(rst), .conv_i(conv), .dxmit_n_i(dxmit_n),
        .int_en_a_o(int_a), .int_en_b_o(int_b), .mraz_a_o(mraz_a), .mraz_b_o(mraz_b),
        .busy_o(busy), .state_o(state), .dvalid_n_o(dvalid_n), .data_side_o(side)
    );

    typedef struct packed {
        logic       lvl;
        logic [7:0] dly;
        logic [3:0] st;
    } vec_t;

    // CONV level, cycles to wait after setting it, expected state (non-inverted run).
    localparam vec_t TBL [12] = '{
        '{1'b1, 8'd6,  4'd2},
        '{1'b0, 8'd6,  4'd3},
        '{1'b1, 8'd30, 4'd4},
        '{1'b0, 8'd30, 4'd5},
        '{1'b1, 8'd6,  4'd4},
        '{1'b0, 8'd6,  4'd1},
        '{1'b1, 8'd6,  4'd1},
        '{1'b0, 8'd50, 4'd2},
        '{1'b1, 8'd6,  4'd3},
        '{1'b0, 8'd6,  4'd4},
        '{1'b1, 8'd30, 4'd1},
        '{1'b0, 8'd50, 4'd2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Integration alternation monitor
    int alt_checks = 0;
    int alt_err = 0;
    int prev_cur = 0;
    int last_side = 0;
    int cur;
    always @(negedge clk) begin
        if (rst) begin
            prev_cur  = 0;
            last_side = 0;
        end else begin
            cur = int_a ? 1 : (int_b ? 2 : 0);
            if (cur != 0 && cur != prev_cur) begin
                alt_checks++;
                if (cur == last_side) begin
                    alt_err++;
                    $display("FAIL R4 alternation actual=%0d expected=%0d", cur, 3 - last_side);
                end
                last_side = cur;
            end
            prev_cur = cur;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks + alt_checks + 1, errors + alt_err + 1);
            $finish;
        end
    end

    task automatic do_reset(input logic lvl);
        @(negedge clk);
        rst  = 1'b1;
        conv = lvl;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int exp_a(input int s);
        return (s == 3 || s == 5) ? 1 : 0;
    endfunction
    function automatic int exp_b(input int s);
        return (s == 4 || s == 6) ? 1 : 0;
    endfunction

    task automatic run_table(input bit inv);
        int e;
        do_reset(inv ? 1'b0 : 1'b1);
        dxmit_n = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            conv = TBL[i].lvl ^ inv;
            repeat (int'(TBL[i].dly)) @(negedge clk);
            e = inv ? 9 - int'(TBL[i].st) : int'(TBL[i].st);
            chk(state == 4'(e), inv ? "R6 mirror state" : "R3/R4/R5 state", state, e);
            chk(int_a == exp_a(e)[0] && int_b == exp_b(e)[0], "R2 integrate enables",
                {int_a, int_b}, {exp_a(e)[0], exp_b(e)[0]});
        end
        dxmit_n = 1'b1;
    endtask

    // Watch window after a CONV change made at a falling edge; n=1 is the first falling edge after.
    int w_brise, w_bfall, w_f1, w_f2;
    logic w_t1, w_t2, w_ma, w_mb, w_ia, w_ib;
    logic [3:0] w_st2, w_st3;

    task automatic watch(input int win, input bit ack);
        logic prev_dv;
        w_brise = -1; w_bfall = -1; w_f1 = -1; w_f2 = -1;
        w_t1 = 1'b0; w_t2 = 1'b0;
        prev_dv = dvalid_n;
        for (int n = 1; n <= win; n++) begin
            @(negedge clk);
            dxmit_n = 1'b1;
            if (busy && w_brise < 0) w_brise = n;
            if (!busy && w_brise >= 0 && w_bfall < 0) w_bfall = n;
            if (!dvalid_n && prev_dv) begin
                if (w_f1 < 0) begin w_f1 = n; w_t1 = side; end
                else if (w_f2 < 0) begin w_f2 = n; w_t2 = side; end
                if (ack) dxmit_n = 1'b0;
            end
            prev_dv = dvalid_n;
            if (n == 2) w_st2 = state;
            if (n == 3) w_st3 = state;
            if (n == 5) begin w_ma = mraz_a; w_mb = mraz_b; w_ia = int_a; w_ib = int_b; end
        end
        dxmit_n = 1'b1;
    endtask

    initial begin
        // R1 reset state for both CONV levels
        rst = 1'b1; conv = 1'b0; dxmit_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(state == 4'd8, "R1 reset state conv low", state, 8);
        chk(dvalid_n && !busy && !int_a && !int_b, "R1 reset outputs", {dvalid_n, busy, int_a, int_b}, 4'b1000);
        conv = 1'b1;
        repeat (3) @(negedge clk);
        chk(state == 4'd1, "R1 reset state conv high", state, 1);
        chk(dvalid_n && !busy, "R1 reset ready/busy", {dvalid_n, busy}, 2'b10);

        // Table walk, then its inverse
        run_table(1'b0);
        run_table(1'b1);

        // Continuous start: timing, tag, synchroniser latency
        do_reset(1'b1);
        repeat (6) @(negedge clk);
        conv = 1'b0;
        repeat (6) @(negedge clk);
        chk(state == 4'd3, "R3 reach state 3", state, 3);
        conv = 1'b1;
        watch(40, 1'b1);
        chk(w_st2 == 4'd3, "R12 no move before third edge", w_st2, 3);
        chk(w_st3 == 4'd4, "R12 move on third edge", w_st3, 4);
        chk(w_brise == 3, "R7 busy rise", w_brise, 3);
        chk(w_bfall - w_brise == LC, "R7 cont busy length", w_bfall - w_brise, LC);
        chk(w_ma && !w_mb, "R7 m/r/az side A only", {w_ma, w_mb}, 2'b10);
        chk(w_f1 - w_brise == DC, "R9 cont ready latency", w_f1 - w_brise, DC);
        chk(w_t1 == 1'b0, "R9 cont ready tag A", w_t1, 0);
        chk(w_f2 < 0, "R9 single ready in cont", w_f2, -1);

        // Hold of the ready flag
        @(negedge clk);
        conv = 1'b0;
        repeat (30) @(negedge clk);
        chk(state == 4'd5, "R4 swap to state 5", state, 5);
        chk(!dvalid_n, "R11 ready held without strobe", dvalid_n, 0);
        chk(side == 1'b1, "R9 cont ready tag B", side, 1);
        dxmit_n = 1'b0;
        @(negedge clk);
        dxmit_n = 1'b1;
        chk(dvalid_n, "R11 ready released by strobe", dvalid_n, 1);
        repeat (4) @(negedge clk);
        chk(dvalid_n, "R11 ready stays released", dvalid_n, 1);

        // Drop to non-continuous from state 4
        conv = 1'b1;
        repeat (5) @(negedge clk);
        chk(state == 4'd4 && busy, "R7 state 4 busy", {state, busy}, {4'd4, 1'b1});
        conv = 1'b0;
        watch(50, 1'b1);
        chk(w_st3 == 4'd1, "R5 busy toggle to state 1", w_st3, 1);
        chk(w_bfall == 3 + LN, "R8 ncont busy length", w_bfall, 3 + LN);
        chk(w_ma && w_mb, "R8 both m/r/az", {w_ma, w_mb}, 2'b11);
        chk(!w_ia && !w_ib, "R8 integrators grounded", {w_ia, w_ib}, 2'b00);
        chk(w_f1 == 3 + DN1, "R10 first ready latency", w_f1, 3 + DN1);
        chk(w_t1 == 1'b0, "R10 first ready tag A", w_t1, 0);
        chk(w_f2 == 3 + DN2, "R10 second ready latency", w_f2, 3 + DN2);
        chk(w_t2 == 1'b1, "R10 second ready tag B", w_t2, 1);

        // Random CONV pattern, alternation monitored (R4)
        do_reset(1'b0);
        dxmit_n = 1'b0;
        for (int i = 0; i < 200; i++) begin
            conv = ~conv;
            repeat ($urandom_range(3, 50)) @(negedge clk);
        end
        chk(alt_checks > 50, "R4 enough integrations observed", alt_checks, 51);

        $display("CHECKS %0d ERRORS %0d", checks + alt_checks, errors + alt_err);
        $finish;
    end
endmodule